// File: doc/BRIEF.md
# Watchdog Countdown Timer

This block is a supervisory countdown timer that sits on a simple word-wide register bus. Software programs a timeout in whole seconds, then sets the run bit and pulses the restart bit. From then on it must keep pulsing restart before the count reaches zero. A prescaler divides the system clock down to a one-second tick. Each tick takes one off the remaining count while the timer runs.

When the count runs out, the block raises one of two request lines for a fixed number of clock cycles. The two lines are a system-reset request and a power-off request, and a mode bit picks which one is used. The block also stops itself and sets a sticky flag. That flag survives the restart it caused, so software can later see that the last restart came from the watchdog. Base-address decoding and the reset or power sequencing that acts on the request lines live outside the block.

Top module: `wdog_core`

## Requirements
- R1: After power-on reset, the control word (offset 0) reads 0x08: stopped, flag clear, reset mode, disabled bit set. The count word (offset 4) reads the default timeout both as reload value (bits 9:0) and as remaining count (bits 25:16). Both request outputs are low.
- R2: Control bit 0 is the run bit and reads back as written. Control bit 3 is read-only and reads as the inverse of the run bit.
- R3: Writing 1 to control bit 7 loads the remaining count from the reload value and restarts the prescaler, whatever the run bit is. Bit 7 always reads 0.
- R4: While the run bit is 1, the remaining count drops by one every TICKS_PER_SEC clock cycles, counted from the restart or from the cycle the run bit was set. While the run bit is 0, the count does not change.
- R5: A write to offset 4 stores bits 9:0 as the reload value, and a written 0 is stored as 1. It does not touch the remaining count, even while running; the new value takes effect at the next restart.
- R6: A tick that finds a remaining count of 1 or less expires the timer. The count becomes 0, the run bit clears, and a request output goes high on that clock edge and stays high for exactly HOLD_CYCLES cycles.
- R7: Control bit 2 selects the expiry action: 0 drives the reset request, 1 drives the power-off request. The other request output stays low.
- R8: Control bit 1 is set on expiry and stays set until 1 is written to bit 1 or a power-on reset occurs. Writing 0 to bit 1 leaves it unchanged.
- R9: A read request returns its data on bus_rdata with bus_rvalid high for one cycle, on the clock edge after the one that sampled the request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset in the 8-byte window (bit 2 selects the word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| sys_rst_req | output | 1 | Expiry request for a system reset |
| pwr_off_req | output | 1 | Expiry request for a power-off |

## Verification
The countdown is exercised in four ways. A plain restart shows that the count falls once per prescaled period. A stop midway shows that the count freezes rather than reloading. A resume with the run bit alone, with no restart, shows that the count carries on from where it stopped. A reload write while running shows that the remaining count is not disturbed. Expiry is driven from small reload values in both action modes, so the exact first and last request cycles and the choice of output line can be told apart. The sticky flag is then written with 0 and with 1, to separate a write-1-to-clear from a plain register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 10;
  localparam int CNT_RD_LSB = 16;

  // control word field positions (decoded by software)
  localparam int BIT_RUN   = 0;
  localparam int BIT_FIRED = 1;
  localparam int BIT_MODE  = 2;
  localparam int BIT_OFF   = 3;
  localparam int BIT_KICK  = 7;

  typedef enum logic {
    ACT_RESET    = 1'b0,
    ACT_POWEROFF = 1'b1
  } act_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int TICKS_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic kick_i,
  output logic tick_o
);
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             at_last;

  assign at_last = (pre_q == LAST);
  assign tick_o  = run_i && at_last && !kick_i;

  always_comb begin
    pre_d = pre_q;
    if (kick_i || !run_i) begin
      pre_d = '0;
    end else if (at_last) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  // R4: the prescaler never passes its terminal value
  a_r4_pre_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);

  // R4: the prescaler stays cleared while stopped
  a_r4_pre_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> pre_q == '0);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int DEF_TIMEOUT = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(DEF_TIMEOUT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;
  logic             last_sec;

  assign step     = run_i && tick_i;
  assign last_sec = (cnt_q <= CNT_W'(1));
  assign expire_o = step && last_sec;
  assign count_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (kick_i) begin
      cnt_d = reload_i;
    end else if (step) begin
      cnt_d = last_sec ? '0 : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: a restart loads the reload value
  a_r3_kick_load: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> cnt_q == $past(reload_i));

  // R4: stopped count stays put
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !kick_i) |=> $stable(cnt_q));

  // R4: one step per tick
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !kick_i && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R6: expiry leaves the count at zero
  a_r6_zero_after: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> cnt_q == '0);
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  act_e mode_i,
  output logic sys_rst_req_o,
  output logic pwr_off_req_o
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam int CHK_W  = $clog2(HOLD_CYCLES + 2);

  logic [HOLD_W-1:0] hold_q, hold_d;
  act_e              sel_q, sel_d;
  logic              req_any;

  assign req_any       = (hold_q != '0);
  assign sys_rst_req_o = req_any && (sel_q == ACT_RESET);
  assign pwr_off_req_o = req_any && (sel_q == ACT_POWEROFF);

  always_comb begin
    hold_d = hold_q;
    sel_d  = sel_q;
    if (expire_i) begin
      hold_d = HOLD_W'(HOLD_CYCLES);
      sel_d  = mode_i;
    end else if (req_any) begin
      hold_d = hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sel_q  <= ACT_RESET;
    end else begin
      hold_q <= hold_d;
      if (expire_i) begin
        sel_q <= sel_d;
      end
    end
  end

  // checker: length of the current request pulse
  logic [CHK_W-1:0] chk_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_len_q <= '0;
    end else if (expire_i) begin
      chk_len_q <= CHK_W'(1);
    end else if (req_any) begin
      chk_len_q <= chk_len_q + 1'b1;
    end else begin
      chk_len_q <= '0;
    end
  end

  // R6: a request pulse lasts the programmed hold length
  a_r6_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_any) |-> $past(chk_len_q) == CHK_W'(HOLD_CYCLES));

  // R6: expiry raises a request on the next cycle
  a_r6_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> (sys_rst_req_o || pwr_off_req_o));

  // R7: never both request lines at once
  a_r7_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_req_o && pwr_off_req_o));

  // R7: requested line follows the mode in force at expiry
  a_r7_mode_sel: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> (pwr_off_req_o == ($past(mode_i) == ACT_POWEROFF)));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DEF_TIMEOUT = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              expire_i,
  output logic              run_o,
  output act_e              mode_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              kick_o
);
  localparam logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(DEF_TIMEOUT);
  localparam int HI_PAD  = DATA_W - CNT_RD_LSB - CNT_W;
  localparam int MID_PAD = CNT_RD_LSB - CNT_W;

  logic              run_q, run_d;
  logic              fired_q, fired_d;
  act_e              mode_q, mode_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;
  logic              wr_ctrl, wr_cnt, rd_any;
  logic              ctrl_en, fired_en;
  logic [DATA_W-1:0] ctrl_word, cnt_word;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata[DATA_W-1:BIT_KICK+1], bus_wdata[6:4],
                         bus_wdata[BIT_OFF], bus_addr[1:0]};

  assign wr_ctrl = bus_req && bus_we && !bus_addr[2];
  assign wr_cnt  = bus_req && bus_we &&  bus_addr[2];
  assign rd_any  = bus_req && !bus_we;
  assign kick_o  = wr_ctrl && bus_wdata[BIT_KICK];

  assign ctrl_en  = wr_ctrl || expire_i;
  assign fired_en = (wr_ctrl && bus_wdata[BIT_FIRED]) || expire_i;

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[BIT_RUN]   = run_q;
    ctrl_word[BIT_FIRED] = fired_q;
    ctrl_word[BIT_MODE]  = (mode_q == ACT_POWEROFF);
    ctrl_word[BIT_OFF]   = !run_q;
    cnt_word = {{HI_PAD{1'b0}}, count_i, {MID_PAD{1'b0}}, reload_q};
  end

  always_comb begin
    run_d    = run_q;
    mode_d   = mode_q;
    fired_d  = fired_q;
    reload_d = reload_q;
    if (wr_ctrl) begin
      run_d  = bus_wdata[BIT_RUN];
      mode_d = bus_wdata[BIT_MODE] ? ACT_POWEROFF : ACT_RESET;
      if (bus_wdata[BIT_FIRED]) begin
        fired_d = 1'b0;
      end
    end
    if (expire_i) begin
      run_d   = 1'b0;
      fired_d = 1'b1;
    end
    if (wr_cnt) begin
      reload_d = (bus_wdata[CNT_W-1:0] == '0) ? CNT_W'(1) : bus_wdata[CNT_W-1:0];
    end
    rdata_d = '0;
    if (rd_any) begin
      rdata_d = bus_addr[2] ? cnt_word : ctrl_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      mode_q   <= ACT_RESET;
      fired_q  <= 1'b0;
      reload_q <= RELOAD_INIT;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (ctrl_en) begin
        run_q  <= run_d;
        mode_q <= mode_d;
      end
      if (fired_en) begin
        fired_q <= fired_d;
      end
      if (wr_cnt) begin
        reload_q <= reload_d;
      end
      rdata_q  <= rdata_d;
      rvalid_q <= rd_any;
    end
  end

  assign run_o      = run_q;
  assign mode_o     = mode_q;
  assign reload_o   = reload_q;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R8: flag holds unless cleared by a write of 1
  a_r8_fired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !(wr_ctrl && bus_wdata[BIT_FIRED])) |=> fired_q);

  // R8: expiry sets the flag
  a_r8_fired_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> fired_q);

  // R6: expiry stops the timer
  a_r6_run_drops: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> !run_q);

  // R9: every read gets exactly one response
  a_r9_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> bus_rvalid);

  a_r9_no_write_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> !bus_rvalid);

  // R5: the reload value is never zero
  a_r5_reload_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q != '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int TICKS_PER_SEC = 50_000_000,
  parameter int DEF_TIMEOUT   = 60,
  parameter int HOLD_CYCLES   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        sys_rst_req,
  output logic        pwr_off_req
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             run, kick, tick, expire;
  act_e             mode;
  logic [CNT_W-1:0] reload, count;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  wdog_regs #(.DEF_TIMEOUT(DEF_TIMEOUT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .count_i    (count),
    .expire_i   (expire),
    .run_o      (run),
    .mode_o     (mode),
    .reload_o   (reload),
    .kick_o     (kick)
  );

  wdog_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .run_i  (run),
    .kick_i (kick),
    .tick_o (tick)
  );

  wdog_countdown #(.DEF_TIMEOUT(DEF_TIMEOUT)) u_countdown (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .run_i    (run),
    .tick_i   (tick),
    .kick_i   (kick),
    .reload_i (reload),
    .count_o  (count),
    .expire_o (expire)
  );

  wdog_action #(.HOLD_CYCLES(HOLD_CYCLES)) u_action (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .expire_i      (expire),
    .mode_i        (mode),
    .sys_rst_req_o (sys_rst_req),
    .pwr_off_req_o (pwr_off_req)
  );
endmodule

// File: tb/wdog_core_bench.sv
module wdog_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 8;
  localparam int DEF_TO     = 60;
  localparam int HOLD       = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        sys_rst_req, pwr_off_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_core #(.TICKS_PER_SEC(TICKS), .DEF_TIMEOUT(DEF_TO), .HOLD_CYCLES(HOLD)) u_wdog_core (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sys_rst_req(sys_rst_req), .pwr_off_req(pwr_off_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cnt_word(input int cnt, input int rel);
    return (32'(cnt) << 16) | 32'(rel);
  endfunction

  task automatic bus_write(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read
  task automatic bus_read(input logic [2:0] addr, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = addr;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  // monitor: compare each response against the oldest expectation
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected response", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // watch an expiry; caller returns on the negedge after the restart edge
  task automatic watch_expiry(input int exp_first, input bit pwr, input string tag);
    int first = -1;
    int last  = -1;
    int wrong = 0;
    for (int i = 1; i <= exp_first + HOLD + 8; i++) begin
      @(negedge clk);
      if ((pwr ? pwr_off_req : sys_rst_req) === 1'b1) begin
        if (first < 0) first = i;
        last = i;
      end
      if ((pwr ? sys_rst_req : pwr_off_req) !== 1'b0) wrong++;
    end
    check({tag, " R6 first request cycle"}, 32'(first), 32'(exp_first));
    check({tag, " R6 last request cycle"}, 32'(last), 32'(exp_first + HOLD - 1));
    check({tag, " R7 other line quiet"}, 32'(wrong), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 reset request low", 32'(sys_rst_req), 32'd0);
    check("R1 poweroff request low", 32'(pwr_off_req), 32'd0);
    bus_read(3'd0, 32'h08, "R1 control after reset");
    bus_read(3'd4, cnt_word(DEF_TO, DEF_TO), "R1 count after reset");

    // R5 zero clamps to one, count untouched; R9 write gives no response
    bus_write(3'd4, 32'd0);
    check("R9 no response to write", 32'(bus_rvalid), 32'd0);
    bus_read(3'd4, cnt_word(DEF_TO, 1), "R5 zero reload stored as one");
    bus_write(3'd4, 32'd5);

    // R3/R4 restart and count down
    bus_write(3'd0, 32'h81);
    repeat (26) @(negedge clk);
    bus_read(3'd4, cnt_word(2, 5), "R4 count after three periods");
    bus_write(3'd0, 32'h00);
    repeat (40) @(negedge clk);
    bus_read(3'd4, cnt_word(2, 5), "R4 count frozen while stopped");
    bus_read(3'd0, 32'h08, "R2 stopped reads disabled");

    // R2 resume without restart; R5 reload write while running
    bus_write(3'd0, 32'h01);
    bus_write(3'd4, 32'd9);
    bus_read(3'd4, cnt_word(2, 9), "R5 running count unaffected by reload write");
    bus_write(3'd0, 32'h00);
    bus_read(3'd0, 32'h08, "R2 run cleared");

    // R3 restart while stopped loads the count, bit 7 reads 0
    bus_write(3'd0, 32'h80);
    bus_read(3'd4, cnt_word(9, 9), "R3 restart while stopped loads count");
    bus_read(3'd0, 32'h08, "R3 restart bit reads zero");
    bus_write(3'd0, 32'h81);
    bus_read(3'd0, 32'h01, "R2 run reads back, R3 bit 7 zero");
    bus_write(3'd0, 32'h00);

    // R6/R7 expiry in reset mode
    bus_write(3'd4, 32'd2);
    bus_write(3'd0, 32'h81);
    watch_expiry(2 * TICKS, 1'b0, "reset mode");
    bus_read(3'd0, 32'h0A, "R8 flag set, R6 run cleared");
    bus_read(3'd4, cnt_word(0, 2), "R6 count zero after expiry");

    // R8 stickiness and write-1-to-clear
    bus_write(3'd0, 32'h00);
    bus_read(3'd0, 32'h0A, "R8 writing zero keeps flag");
    bus_write(3'd0, 32'h02);
    bus_read(3'd0, 32'h08, "R8 writing one clears flag");

    // R7 power-off mode
    bus_write(3'd4, 32'd1);
    bus_write(3'd0, 32'h85);
    watch_expiry(TICKS, 1'b1, "poweroff mode");
    bus_read(3'd0, 32'h0E, "R7 mode kept, R8 flag set");
    bus_write(3'd0, 32'h06);
    bus_read(3'd0, 32'h0C, "R8 cleared in poweroff mode");

    repeat (4) @(negedge clk);
    check("R9 all responses seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule